// File: doc/BRIEF.md
# I2C Serial Memory Slave Engine

This block is the bus-facing half of a byte-addressed serial memory of 4096 locations. A fast system clock oversamples the two bus lines. The block finds START and STOP conditions, shifts bytes in and out, and returns acknowledges by driving an open-drain enable for the data line. The memory array sits behind a simple request interface, and so does the path that commits a page of written data to it.

A transaction opens with a control byte. That byte carries a fixed device code, three chip-select bits that must match the strap inputs, and a direction bit. A write continues with a two-byte word address and then any number of data bytes. The data bytes stay inside one 32-byte page. At STOP the block asks the memory side to commit the page. While that commit is busy the block stays silent on the bus, so a bus master can poll for the end of the commit.

Reads use one internal address pointer, which always holds the last accessed location plus one. This gives current-address reads and sequential reads. A random read is a write that stops after the address, followed by a repeated START and a read control byte.

Top module: `i2cmem_slave`

## Requirements
- R1: While reset is held and right after it, `sda_oe_o`, `rd_o`, `wr_o` and `commit_o` are all low.
- R2: The control byte (bits 7..4 device code, bits 3..1 chip select, bit 0 direction with 1 meaning read) is acknowledged only when the code is 4'b1010 and the chip select equals `strap_i`. Otherwise SDA stays released, and the block ignores the bus until the next START.
- R3: After a write control byte, two address bytes follow, high byte first. Each is acknowledged. Only the low 4 bits of the high byte are used, and its top 4 bits have no effect on the address.
- R4: Each data byte of a write is acknowledged and produces one single-cycle `wr_o` with the pointer on `addr_o` and the byte on `wdata_o`. The pointer then advances in its low 5 bits only, so the writes wrap inside the current 32-byte page.
- R5: `commit_o` pulses for exactly one cycle at the first STOP after one or more data bytes were written. A STOP that ends a transaction without written data produces no pulse.
- R6: While `busy_i` is high the block acknowledges nothing, its own control byte included.
- R7: An accepted read control byte issues `rd_o` at the pointer. The returned byte is sent MSB first, and the pointer becomes that address plus 1. A current-address read therefore returns the location after the last one accessed.
- R8: In a read, a master ACK after a data byte makes the block fetch and send the next address. A master NACK ends the transfer with SDA released.
- R9: During a read the pointer rolls over from 0xFFF to 0x000.
- R10: A START in the middle of a byte aborts the transfer, and the next byte is decoded as a new control byte.
- R11: After STOP the block is idle. Bytes clocked without a new START are neither acknowledged nor turned into requests.
- R12: `sda_oe_o` changes only while SCL is low. The acknowledge is driven for the ninth clock and released at the next SCL falling edge.
- R13: A random read returns the byte at the address given in the write phase that comes before the repeated START.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than SCL |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe_o | output | 1 | 1 pulls the data line low |
| strap_i | input | 3 | Chip-select straps |
| busy_i | input | 1 | Commit cycle in progress |
| rd_o | output | 1 | Read request, one cycle |
| wr_o | output | 1 | Page-buffer write request, one cycle |
| addr_o | output | 12 | Request address (internal pointer) |
| wdata_o | output | 8 | Write data |
| rdata_i | input | 8 | Read data, valid the cycle after `rd_o` |
| commit_o | output | 1 | Commit the page buffer, one cycle |

## Verification
The bench acts as a bus master and drives the following patterns:
- Control bytes with a wrong device code and with a wrong chip select. These separate address matching from acknowledge generation.
- Byte writes, and a page write that crosses its page end. Reading the data back tells page wrap apart from a full-width increment.
- Current, random and sequential reads, one of them across the top of the array. These separate how the pointer advances from how the address is loaded.
- A control byte polled while a commit runs, a START in the middle of a byte, and bytes sent after STOP with no START. These check each of the silence rules on its own.

On every clock the bench also checks that the data-line drive never moves while SCL is high.

// File: rtl/i2cmem_pkg.sv
package i2cmem_pkg;
  localparam logic [3:0] DEV_CODE = 4'b1010;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_CTRL,
    PH_AHI,
    PH_ALO,
    PH_WDATA,
    PH_RDATA
  } phase_e;
endpackage

// File: rtl/i2cmem_sync.sv
module i2cmem_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_q, sda_q;
  logic scl_p, sda_p, scl_s, sda_s;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        scl_q[g] <= 1'b1;
        sda_q[g] <= 1'b1;
      end else if (g == 0) begin
        scl_q[g] <= scl_i;
        sda_q[g] <= sda_i;
      end else begin
        scl_q[g] <= scl_q[g-1];
        sda_q[g] <= sda_q[g-1];
      end
    end
  end

  assign scl_s = scl_q[STAGES-1];
  assign sda_s = sda_q[STAGES-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_p <= scl_s;
      sda_p <= sda_s;
    end
  end

  assign sda_s_o    = sda_s;
  assign scl_rise_o = scl_s & ~scl_p;
  assign scl_fall_o = ~scl_s & scl_p;
  assign start_o    = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_o     = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/i2cmem_ptr.sv
module i2cmem_ptr #(
  parameter int ADDR_W     = 12,
  parameter int PAGE_BYTES = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_hi_i,
  input  logic              load_lo_i,
  input  logic              step_page_i,
  input  logic              step_full_i,
  input  logic [7:0]        byte_i,
  output logic [ADDR_W-1:0] ptr_o
);
  localparam int HI_W   = ADDR_W - 8;
  localparam int PAGE_W = $clog2(PAGE_BYTES);

  logic [ADDR_W-1:0] ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
    end else if (load_hi_i) begin
      ptr_q[ADDR_W-1:8] <= byte_i[HI_W-1:0];
    end else if (load_lo_i) begin
      ptr_q[7:0] <= byte_i;
    end else if (step_page_i) begin
      ptr_q[PAGE_W-1:0] <= ptr_q[PAGE_W-1:0] + 1'b1;
    end else if (step_full_i) begin
      ptr_q <= ptr_q + 1'b1;
    end
  end

  assign ptr_o = ptr_q;
endmodule

// File: rtl/i2cmem_fsm.sv
module i2cmem_fsm
  import i2cmem_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sda_s_i,
  input  logic       scl_rise_i,
  input  logic       scl_fall_i,
  input  logic       start_i,
  input  logic       stop_i,
  input  logic [2:0] strap_i,
  input  logic       busy_i,
  input  logic [7:0] rdata_i,
  output logic [7:0] byte_o,
  output logic       load_hi_o,
  output logic       load_lo_o,
  output logic       step_page_o,
  output logic       step_full_o,
  output logic       rd_o,
  output logic       wr_o,
  output logic [7:0] wdata_o,
  output logic       commit_o,
  output logic       sda_oe_o
);
  phase_e     phase;
  logic [3:0] cnt;
  logic [7:0] shreg, tx, rbuf;
  logic       ack_ok, more, wrote, rd_q;
  logic [7:0] byte_nx;
  logic       match;

  assign byte_nx = {shreg[6:0], sda_s_i};
  assign match   = (byte_nx[7:4] == DEV_CODE) && (byte_nx[3:1] == strap_i) && !busy_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q <= 1'b0;
      rbuf <= '0;
    end else begin
      rd_q <= rd_o;
      if (rd_q) rbuf <= rdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase       <= PH_IDLE;
      cnt         <= '0;
      shreg       <= '0;
      tx          <= '0;
      ack_ok      <= 1'b0;
      more        <= 1'b0;
      wrote       <= 1'b0;
      load_hi_o   <= 1'b0;
      load_lo_o   <= 1'b0;
      step_page_o <= 1'b0;
      step_full_o <= 1'b0;
      rd_o        <= 1'b0;
      wr_o        <= 1'b0;
      wdata_o     <= '0;
      commit_o    <= 1'b0;
      sda_oe_o    <= 1'b0;
    end else begin
      load_hi_o   <= 1'b0;
      load_lo_o   <= 1'b0;
      step_page_o <= 1'b0;
      step_full_o <= 1'b0;
      rd_o        <= 1'b0;
      wr_o        <= 1'b0;
      commit_o    <= 1'b0;
      if (start_i) begin
        phase    <= PH_CTRL;
        cnt      <= '0;
        sda_oe_o <= 1'b0;
      end else if (stop_i) begin
        phase    <= PH_IDLE;
        sda_oe_o <= 1'b0;
        if (wrote) begin
          commit_o <= 1'b1;
          wrote    <= 1'b0;
        end
      end else if (phase != PH_IDLE) begin
        if (scl_rise_i) begin
          if (phase == PH_RDATA) begin
            if (cnt < 4'd8) begin
              cnt <= cnt + 1'b1;
            end else if (cnt == 4'd9) begin
              more <= ~sda_s_i;
              if (!sda_s_i) begin
                rd_o        <= 1'b1;
                step_full_o <= 1'b1;
              end
            end
          end else if (cnt < 4'd8) begin
            shreg <= byte_nx;
            cnt   <= cnt + 1'b1;
            if (cnt == 4'd7) begin
              ack_ok <= 1'b1;
              unique case (phase)
                PH_CTRL: begin
                  ack_ok <= match;
                  if (match && byte_nx[0]) begin
                    rd_o        <= 1'b1;
                    step_full_o <= 1'b1;
                  end
                end
                PH_AHI:  load_hi_o <= 1'b1;
                PH_ALO:  load_lo_o <= 1'b1;
                PH_WDATA: begin
                  wr_o        <= 1'b1;
                  wdata_o     <= byte_nx;
                  step_page_o <= 1'b1;
                  wrote       <= 1'b1;
                end
                default: ;
              endcase
            end
          end
        end else if (scl_fall_i) begin
          if (cnt == 4'd8) begin
            cnt      <= 4'd9;
            sda_oe_o <= (phase != PH_RDATA) && ack_ok;
          end else if (cnt == 4'd9) begin
            cnt      <= '0;
            sda_oe_o <= 1'b0;
            if (phase == PH_RDATA) begin
              if (more) begin
                tx       <= rbuf;
                sda_oe_o <= ~rbuf[7];
              end else begin
                phase <= PH_IDLE;
              end
            end else if (!ack_ok) begin
              phase <= PH_IDLE;
            end else begin
              unique case (phase)
                PH_CTRL: begin
                  if (shreg[0]) begin
                    phase    <= PH_RDATA;
                    tx       <= rbuf;
                    sda_oe_o <= ~rbuf[7];
                  end else begin
                    phase <= PH_AHI;
                  end
                end
                PH_AHI:  phase <= PH_ALO;
                default: phase <= PH_WDATA;
              endcase
            end
          end else if (phase == PH_RDATA && cnt != 4'd0) begin
            tx       <= {tx[6:0], 1'b0};
            sda_oe_o <= ~tx[6];
          end
        end
      end
    end
  end

  assign byte_o = shreg;
endmodule

// File: rtl/i2cmem_slave.sv
module i2cmem_slave #(
  parameter int ADDR_W      = 12,
  parameter int PAGE_BYTES  = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  input  logic [2:0]        strap_i,
  input  logic              busy_i,
  output logic              rd_o,
  output logic              wr_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [7:0]        wdata_o,
  input  logic [7:0]        rdata_i,
  output logic              commit_o
);
  logic sda_s, scl_rise, scl_fall, start, stop;
  logic load_hi, load_lo, step_page, step_full;
  logic [7:0] byte_q;

  i2cmem_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .sda_s_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start), .stop_o(stop)
  );

  i2cmem_fsm u_fsm (
    .clk_i, .rst_ni,
    .sda_s_i(sda_s), .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
    .start_i(start), .stop_i(stop),
    .strap_i, .busy_i, .rdata_i,
    .byte_o(byte_q), .load_hi_o(load_hi), .load_lo_o(load_lo),
    .step_page_o(step_page), .step_full_o(step_full),
    .rd_o, .wr_o, .wdata_o, .commit_o, .sda_oe_o
  );

  i2cmem_ptr #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES)) u_ptr (
    .clk_i, .rst_ni,
    .load_hi_i(load_hi), .load_lo_i(load_lo),
    .step_page_i(step_page), .step_full_i(step_full),
    .byte_i(byte_q), .ptr_o(addr_o)
  );
endmodule

// File: rtl/i2cmem_chk.sv
module i2cmem_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic scl_i,
  input logic sda_oe_o,
  input logic busy_i,
  input logic rd_o,
  input logic wr_o,
  input logic commit_o
);
  logic [2:0] hi_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hi_cnt <= '0;
    else if (!scl_i) hi_cnt <= '0;
    else if (hi_cnt != 3'd7) hi_cnt <= hi_cnt + 1'b1;
  end

  // R12
  oe_scl_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scl_i && hi_cnt >= 3'd4) |-> $stable(sda_oe_o));

  // R5
  commit_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |=> !commit_o);

  // R4
  wr_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_o |=> !wr_o);

  // R7
  rd_wr_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_o && wr_o));

  // R6
  busy_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && $past(busy_i)) |-> !$rose(sda_oe_o));
endmodule

bind i2cmem_slave i2cmem_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .scl_i(scl_i), .sda_oe_o(sda_oe_o),
  .busy_i(busy_i), .rd_o(rd_o), .wr_o(wr_o), .commit_o(commit_o)
);

// File: tb/i2cmem_slave_tb.sv
module i2cmem_slave_tb;
  localparam int H = 16;
  localparam int BUSY_CYC = 3000;
  localparam logic [2:0] STRAP = 3'b101;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_line;
  logic sda_oe_o, rd_o, wr_o, commit_o;
  logic [11:0] addr_o;
  logic [7:0] wdata_o;
  logic [7:0] rdata_i = '0;
  logic busy_i;
  int busy_cnt = 0;
  int n_cmp = 0, n_bad = 0;
  int n_commit = 0, n_rd = 0, n_wr = 0;
  int cyc = 0, hi_run = 0;
  logic oe_prev = 1'b0;
  logic [7:0] mem [int];
  logic [7:0] pend [int];
  logic [7:0] exp_mem [int];
  logic [7:0] exp_pend [int];
  int exp_ptr = 0;

  always #4 clk = ~clk;

  assign sda_line = sda_m & ~sda_oe_o;
  assign busy_i = (busy_cnt > 0);

  i2cmem_slave u_dut (
    .clk_i(clk), .rst_ni, .scl_i(scl_m), .sda_i(sda_line), .sda_oe_o,
    .strap_i(STRAP), .busy_i, .rd_o, .wr_o, .addr_o, .wdata_o, .rdata_i, .commit_o
  );

  function automatic logic [7:0] init_val(int a);
    return 8'((a * 37 + 11) & 255);
  endfunction

  function automatic logic [7:0] mem_get(int a);
    return mem.exists(a) ? mem[a] : init_val(a);
  endfunction

  function automatic logic [7:0] exp_get(int a);
    return exp_mem.exists(a) ? exp_mem[a] : init_val(a);
  endfunction

  // memory side responder
  always @(posedge clk) begin
    if (rd_o) begin rdata_i <= mem_get(int'(addr_o)); n_rd++; end
    if (wr_o) begin pend[int'(addr_o)] = wdata_o; n_wr++; end
    if (commit_o) begin
      foreach (pend[k]) mem[k] = pend[k];
      pend.delete();
      n_commit++;
      busy_cnt <= BUSY_CYC;
    end else if (busy_cnt > 0) busy_cnt <= busy_cnt - 1;
  end

  task automatic check(string req, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // per-clock bus rule reference: drive frozen while SCL high (R12)
  always @(negedge clk) begin
    cyc++;
    if (rst_ni) begin
      if (scl_m && hi_run >= 4) check("R12 drive moved while SCL high", int'(sda_oe_o), int'(oe_prev));
      hi_run = scl_m ? hi_run + 1 : 0;
      oe_prev = sda_oe_o;
    end
    if (cyc > 190000) begin
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=<190000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic hold(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; hold(H);
    scl_m = 1'b1; hold(H);
    sda_m = 1'b0; hold(H);
    scl_m = 1'b0; hold(2);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; hold(H);
    scl_m = 1'b1; hold(H);
    sda_m = 1'b1; hold(H);
  endtask

  task automatic send_bits(logic [7:0] b, int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = b[i]; hold(H);
      scl_m = 1'b1; hold(H);
      scl_m = 1'b0; hold(2);
    end
  endtask

  task automatic send_byte(logic [7:0] b, output logic ack);
    send_bits(b, 8);
    sda_m = 1'b1; hold(H);
    scl_m = 1'b1; hold(H / 2);
    ack = ~sda_line; hold(H / 2);
    scl_m = 1'b0; hold(2);
  endtask

  task automatic recv_byte(output logic [7:0] b, input logic give_ack);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      hold(H);
      scl_m = 1'b1; hold(H / 2);
      b[i] = sda_line; hold(H / 2);
      scl_m = 1'b0; hold(2);
    end
    sda_m = ~give_ack; hold(H);
    scl_m = 1'b1; hold(H);
    scl_m = 1'b0; hold(2);
    sda_m = 1'b1;
  endtask

  function automatic logic [7:0] ctrl(logic rw);
    return {4'b1010, STRAP, rw};
  endfunction

  task automatic poll_ready(string req);
    logic a;
    bus_start(); send_byte(ctrl(1'b0), a);
    check({req, " first poll during commit not acked"}, int'(a), 0);
    for (int t = 0; t < 40 && !a; t++) begin
      hold(100);
      bus_start(); send_byte(ctrl(1'b0), a);
    end
    check({req, " poll acked after commit"}, int'(a), 1);
    bus_stop();
  endtask

  task automatic do_write(logic [7:0] hi, logic [7:0] lo, logic [7:0] d[$], string req);
    logic a;
    int base, pa;
    int c0;
    c0 = n_commit;
    base = int'({hi[3:0], lo});
    bus_start();
    send_byte(ctrl(1'b0), a); check({req, " ctrl ack"}, int'(a), 1);
    send_byte(hi, a); check("R3 addr hi ack", int'(a), 1);
    send_byte(lo, a); check("R3 addr lo ack", int'(a), 1);
    foreach (d[i]) begin
      send_byte(d[i], a); check("R4 data ack", int'(a), 1);
      pa = (base & 12'hFE0) | ((base + i) & 31);
      exp_pend[pa] = d[i];
    end
    exp_ptr = (base & 12'hFE0) | ((base + d.size()) & 31);
    bus_stop();
    hold(4);
    check("R5 one commit per write", n_commit - c0, 1);
    foreach (exp_pend[k]) exp_mem[k] = exp_pend[k];
    exp_pend.delete();
    poll_ready("R6");
  endtask

  task automatic read_bytes(int n, string req);
    logic [7:0] b;
    for (int i = 0; i < n; i++) begin
      recv_byte(b, i != n - 1);
      check(req, int'(b), int'(exp_get(exp_ptr)));
      exp_ptr = (exp_ptr + 1) & 12'hFFF;
    end
  endtask

  task automatic rand_read(int addr, int n, string req);
    logic a;
    bus_start();
    send_byte(ctrl(1'b0), a); check({req, " ctrl w ack"}, int'(a), 1);
    send_byte(8'(addr >> 8), a); check("R3 hi ack", int'(a), 1);
    send_byte(8'(addr), a); check("R3 lo ack", int'(a), 1);
    exp_ptr = addr & 12'hFFF;
    bus_start();
    send_byte(ctrl(1'b1), a); check({req, " ctrl r ack"}, int'(a), 1);
    read_bytes(n, req);
    bus_stop();
  endtask

  task automatic cur_read(int n, string req);
    logic a;
    bus_start();
    send_byte(ctrl(1'b1), a); check({req, " ctrl ack"}, int'(a), 1);
    read_bytes(n, req);
    bus_stop();
  endtask

  initial begin
    logic a;
    int c0, r0, w0;
    logic [7:0] d[$];
    hold(3);
    // R1
    check("R1 oe in reset", int'(sda_oe_o), 0);
    check("R1 req in reset", int'(rd_o | wr_o | commit_o), 0);
    rst_ni = 1'b1;
    hold(5);
    check("R1 oe after reset", int'(sda_oe_o), 0);

    // R2 wrong device code, wrong chip select
    bus_start(); send_byte({4'b1011, STRAP, 1'b0}, a);
    check("R2 wrong code nacked", int'(a), 0);
    bus_start(); send_byte({4'b1010, 3'b100, 1'b1}, a);
    check("R2 wrong strap nacked", int'(a), 0);
    send_byte(8'h00, a);
    check("R2 ignored until start", int'(a), 0);
    bus_stop();

    // byte write, high nibble of address is don't care (R3)
    d = '{8'hA5};
    do_write(8'hF1, 8'h23, d, "R4");
    cur_read(1, "R7 current read after write");
    check("R7 pointer after current read", exp_ptr, 12'h125);

    // R13 random read, then R7 current follows it
    c0 = n_commit;
    rand_read(12'h123, 1, "R13 random read");
    cur_read(1, "R7 current read follows random");
    check("R5 no commit without data", n_commit - c0, 0);

    // R4 page wrap
    d = '{8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h66};
    do_write(8'h00, 8'h3C, d, "R4");
    check("R4 pointer wraps in page", exp_ptr, 12'h022);
    rand_read(12'h03C, 4, "R8 sequential page end");
    rand_read(12'h020, 3, "R4 wrapped data");

    // R9 rollover
    rand_read(12'hFFE, 3, "R9 rollover read");
    check("R9 pointer wrapped", exp_ptr, 12'h001);
    cur_read(1, "R9 current after rollover");

    // R10 start inside a byte
    bus_start(); send_bits(8'hA0, 4);
    bus_start(); send_byte(ctrl(1'b1), a);
    check("R10 ctrl after abort acked", int'(a), 1);
    read_bytes(1, "R10 data after abort");
    bus_stop();

    // R11 bytes after stop with no start
    r0 = n_rd; w0 = n_wr;
    scl_m = 1'b0; hold(2);
    send_byte(ctrl(1'b1), a);
    check("R11 no ack without start", int'(a), 0);
    send_byte(8'h5A, a);
    check("R11 second byte no ack", int'(a), 0);
    check("R11 no requests", (n_rd - r0) + (n_wr - w0), 0);
    bus_stop();

    // R8 NACK releases line
    cur_read(2, "R8 seq two bytes");
    check("R8 line released after nack", int'(sda_oe_o), 0);

    hold(20);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule